// File: doc/BRIEF.md
# Shadow ROM Memory Decoder

This block sits between the address and strobe lines of an 8-bit CPU and the onboard memory of a single board. It splits the 64K address space into eight 8K blocks. Each block carries its own two-bit mode, taken from a static configuration vector. The mode sends an access to the external bus, to onboard RAM, to onboard ROM, or to a shadow arrangement. In the shadow arrangement, reads return ROM contents and writes land in the RAM underneath. This holds until a kill event hands the block over to RAM for both directions. The ROM is half the size of the address space, so the ROM address wraps and the upper 32K sees the same ROM as the lower 32K.

The kill state is held in a small two-state machine, with states `SHD_LIVE` and `SHD_KILLED`. Reset puts it in `SHD_LIVE`. A strap input chooses the kill source. With the latched source, any clock edge that sees the storage-card select asserted takes the transition `LIVE -> KILLED`, and only reset takes it back. With the level source, the machine follows bit 0 of the parallel output register at every edge. A 1 in that bit takes `LIVE -> KILLED` and a 0 takes `KILLED -> LIVE`, which lets firmware bank the ROM in and out. The chip selects themselves are combinational from the address, the strobes and the current state.

Top module: `shadow_rom_decoder`

## Requirements
- R1: The block index is `addr[15:13]`, and block i takes its mode from `blk_mode_cfg[2i+1:2i]`. Mode codes: 00 external, 01 ROM, 10 RAM, 11 shadow.
- R2: In mode 00 an access asserts `ext_acc` only, and neither onboard select is asserted.
- R3: In mode 10 both reads and writes assert `ram_sel` only.
- R4: In mode 01 a read asserts `rom_sel` and a write asserts `ram_sel`. RAM is never selected for a read.
- R5: In mode 11 a write asserts `ram_sel`. A read asserts `rom_sel` while the state is `SHD_LIVE` and asserts `ram_sel` once the state is `SHD_KILLED`.
- R6: `rom_addr` equals `addr[14:0]` for every address, so addresses 0x8000 and above reach the same ROM bytes as the lower half.
- R7: After reset the state is `SHD_LIVE`, so shadow blocks read from ROM.
- R8: With `kill_src_sel`=0, a clock edge that samples `card_sel`=1 moves the state to `SHD_KILLED`. The state then stays killed after `card_sel` falls, until reset.
- R9: With `kill_src_sel`=1, the state after each clock edge is `SHD_KILLED` if `par_kill` was 1 at that edge and `SHD_LIVE` if it was 0.
- R10: With `rd`=0 and `wr`=0, `ram_sel`, `rom_sel` and `ext_acc` are all 0.
- R11: With `rd` and `wr` both 1, the access is routed as a read.
- R12: With `blk_mode_cfg` all zeros, no access anywhere asserts `ram_sel` or `rom_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the kill state |
| rst_n | input | 1 | Asynchronous active-low reset, re-arms shadow |
| addr | input | 16 | CPU address |
| rd | input | 1 | Memory read strobe |
| wr | input | 1 | Memory write strobe |
| blk_mode_cfg | input | 16 | Two mode bits per 8K block |
| kill_src_sel | input | 1 | 0: latched card-select kill, 1: parallel-bit level kill |
| card_sel | input | 1 | Storage-card select, active high |
| par_kill | input | 1 | Parallel output bit 0, 1 means killed |
| ram_sel | output | 1 | Onboard RAM select |
| rom_sel | output | 1 | Onboard ROM select |
| ext_acc | output | 1 | Access goes to the external bus |
| rom_addr | output | 15 | ROM address with mirroring applied |

## Verification
The hardest case to reach is the sticky latched kill. The state must survive after `card_sel` falls and must keep its value until reset. The stimulus pulses `card_sel` for one clock. It then sweeps the whole address space with a configuration that places every mode in two blocks, so every shadow block is seen reading RAM. After that it resets, switches to the level source and toggles `par_kill` to show that the level source can be undone. It also probes the cycle just before the kill edge, to confirm the routing still reads ROM there.

// File: rtl/shadow_dec_pkg.sv
package shadow_dec_pkg;

    typedef enum logic [1:0] {
        BLK_EXTERNAL = 2'b00,
        BLK_ROM_ONLY = 2'b01,
        BLK_RAM_ONLY = 2'b10,
        BLK_SHADOW   = 2'b11
    } blk_mode_e;

    typedef enum logic {
        SHD_LIVE   = 1'b0,
        SHD_KILLED = 1'b1
    } shd_state_e;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'b00,
        ACC_READ  = 2'b01,
        ACC_WRITE = 2'b10
    } acc_kind_e;

    typedef struct packed {
        logic ram;
        logic rom;
        logic ext;
    } route_t;

endpackage

// File: rtl/shadow_kill_fsm.sv
module shadow_kill_fsm
    import shadow_dec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic src_level,
    input  logic card_sel,
    input  logic par_kill,
    output logic killed
);

    shd_state_e state_q;
    shd_state_e state_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SHD_LIVE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SHD_LIVE: begin
                if (src_level) begin
                    if (par_kill) state_d = SHD_KILLED;
                end else begin
                    if (card_sel) state_d = SHD_KILLED;
                end
            end
            SHD_KILLED: begin
                if (src_level && !par_kill) state_d = SHD_LIVE;
            end
            default: state_d = SHD_LIVE;
        endcase
    end

    // Output.
    always_comb begin
        killed = (state_q == SHD_KILLED);
    end

endmodule

// File: rtl/shadow_blk_lookup.sv
module shadow_blk_lookup
    import shadow_dec_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int BLK_CNT = 8
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic [2*BLK_CNT-1:0] cfg,
    output blk_mode_e            mode
);

    localparam int BLK_W = $clog2(BLK_CNT);

    blk_mode_e modes [BLK_CNT];

    for (genvar g = 0; g < BLK_CNT; g++) begin : g_unpack
        assign modes[g] = blk_mode_e'(cfg[2*g +: 2]);
    end

    logic [BLK_W-1:0] idx;

    always_comb begin
        idx  = addr[ADDR_W-1 -: BLK_W];
        mode = modes[idx];
    end

endmodule

// File: rtl/shadow_router.sv
module shadow_router
    import shadow_dec_pkg::*;
(
    input  blk_mode_e mode,
    input  acc_kind_e kind,
    input  logic      killed,
    output route_t    route
);

    always_comb begin
        route = '0;
        if (kind != ACC_IDLE) begin
            unique case (mode)
                BLK_EXTERNAL: route.ext = 1'b1;
                BLK_RAM_ONLY: route.ram = 1'b1;
                BLK_ROM_ONLY: begin
                    if (kind == ACC_READ) route.rom = 1'b1;
                    else                  route.ram = 1'b1;
                end
                BLK_SHADOW: begin
                    if (kind == ACC_READ && !killed) route.rom = 1'b1;
                    else                             route.ram = 1'b1;
                end
                default: route = '0;
            endcase
        end
    end

endmodule

// File: rtl/shadow_rom_decoder.sv
module shadow_rom_decoder
    import shadow_dec_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int BLK_CNT = 8,
    parameter int ROM_AW  = 15
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 rd,
    input  logic                 wr,
    input  logic [2*BLK_CNT-1:0] blk_mode_cfg,
    input  logic                 kill_src_sel,
    input  logic                 card_sel,
    input  logic                 par_kill,
    output logic                 ram_sel,
    output logic                 rom_sel,
    output logic                 ext_acc,
    output logic [ROM_AW-1:0]    rom_addr
);

    blk_mode_e mode;
    acc_kind_e kind;
    route_t    route;
    logic      killed;

    shadow_kill_fsm u_kill (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_level (kill_src_sel),
        .card_sel  (card_sel),
        .par_kill  (par_kill),
        .killed    (killed)
    );

    shadow_blk_lookup #(
        .ADDR_W  (ADDR_W),
        .BLK_CNT (BLK_CNT)
    ) u_lookup (
        .addr (addr),
        .cfg  (blk_mode_cfg),
        .mode (mode)
    );

    // A read strobe wins when both strobes are high.
    always_comb begin
        if (rd)      kind = ACC_READ;
        else if (wr) kind = ACC_WRITE;
        else         kind = ACC_IDLE;
    end

    shadow_router u_route (
        .mode   (mode),
        .kind   (kind),
        .killed (killed),
        .route  (route)
    );

    always_comb begin
        ram_sel  = route.ram;
        rom_sel  = route.rom;
        ext_acc  = route.ext;
        rom_addr = addr[ROM_AW-1:0];
    end

endmodule

// File: rtl/shadow_dec_checker.sv
module shadow_dec_checker (
    input logic clk,
    input logic rst_n,
    input logic rd,
    input logic wr,
    input logic kill_src_sel,
    input logic card_sel,
    input logic par_kill,
    input logic ram_sel,
    input logic rom_sel,
    input logic ext_acc,
    input logic killed
);

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_sel, rom_sel, ext_acc})); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd && !wr) |-> !(ram_sel || rom_sel || ext_acc)); // R10

    AST_WRITE_NOT_ROM: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !rd) |-> !rom_sel); // R4

    AST_SRC_A_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        (!kill_src_sel && card_sel) |=> killed); // R8

    AST_SRC_A_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!kill_src_sel && killed) |=> killed); // R8

    AST_SRC_B_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        kill_src_sel |=> (killed == $past(par_kill))); // R9

endmodule

bind shadow_rom_decoder shadow_dec_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd           (rd),
    .wr           (wr),
    .kill_src_sel (kill_src_sel),
    .card_sel     (card_sel),
    .par_kill     (par_kill),
    .ram_sel      (ram_sel),
    .rom_sel      (rom_sel),
    .ext_acc      (ext_acc),
    .killed       (killed)
);

// File: tb/shadow_rom_decoder_tb_top.sv
module shadow_rom_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        rd = 1'b0;
    logic        wr = 1'b0;
    logic [15:0] blk_mode_cfg = '0;
    logic        kill_src_sel = 1'b0;
    logic        card_sel = 1'b0;
    logic        par_kill = 1'b0;
    logic        ram_sel;
    logic        rom_sel;
    logic        ext_acc;
    logic [14:0] rom_addr;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    shadow_rom_decoder dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr         (addr),
        .rd           (rd),
        .wr           (wr),
        .blk_mode_cfg (blk_mode_cfg),
        .kill_src_sel (kill_src_sel),
        .card_sel     (card_sel),
        .par_kill     (par_kill),
        .ram_sel      (ram_sel),
        .rom_sel      (rom_sel),
        .ext_acc      (ext_acc),
        .rom_addr     (rom_addr)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%h rd=%0b wr=%0b got=%h exp=%h", req, addr, rd, wr, got, exp);
        end
    endtask

    // Expected {ram,rom,ext} from the requirements.
    function automatic logic [2:0] exp_route(input logic [1:0] m, input logic r, input logic w,
                                             input logic k);
        if (!r && !w) return 3'b000;
        case (m)
            2'b00: return 3'b001;
            2'b10: return 3'b100;
            2'b01: return r ? 3'b010 : 3'b100;
            default: return (r && !k) ? 3'b010 : 3'b100;
        endcase
    endfunction

    function automatic string tag_for(input logic [1:0] m, input logic r, input logic w,
                                      input bit zero_cfg);
        if (zero_cfg) return "R12";
        if (!r && !w) return "R10";
        if (r && w)   return "R11";
        case (m)
            2'b00: return "R2";
            2'b10: return "R3";
            2'b01: return "R4";
            default: return "R5";
        endcase
    endfunction

    // R1 block decode, swept over the whole space.
    task automatic sweep(input logic k, input bit zero_cfg);
        for (int a = 0; a < 65536; a += 256) begin
            for (int t = 0; t < 4; t++) begin
                logic [1:0] m;
                addr = a[15:0] + 16'(t * 37);
                {rd, wr} = t[1:0];
                m = blk_mode_cfg[2*addr[15:13] +: 2];
                #1;
                check(tag_for(m, rd, wr, zero_cfg), {29'd0, ram_sel, rom_sel, ext_acc},
                      {29'd0, exp_route(m, rd, wr, k)});
                check("R6", {17'd0, rom_addr}, {17'd0, addr[14:0]});
            end
        end
        rd = 1'b0;
        wr = 1'b0;
    endtask

    task automatic shadow_read(input string req, input logic k);
        addr = 16'h6123;  // block 3, mode 11 in the base config
        rd = 1'b1;
        wr = 1'b0;
        #1;
        check(req, {29'd0, ram_sel, rom_sel, ext_acc}, {29'd0, exp_route(2'b11, 1'b1, 1'b0, k)});
        rd = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        // block i mode = i % 4
        blk_mode_cfg = 16'b11_10_01_00_11_10_01_00;
        do_reset();
        shadow_read("R7", 1'b0);
        sweep(1'b0, 1'b0);

        // Latched source.
        kill_src_sel = 1'b0;
        @(negedge clk);
        card_sel = 1'b1;
        #2;
        shadow_read("R8", 1'b0);  // before the edge
        @(negedge clk);
        card_sel = 1'b0;
        #2;
        shadow_read("R8", 1'b1);
        repeat (5) @(negedge clk);
        shadow_read("R8", 1'b1);
        sweep(1'b1, 1'b0);

        do_reset();
        shadow_read("R7", 1'b0);

        // Level source.
        kill_src_sel = 1'b1;
        par_kill = 1'b1;
        @(negedge clk);
        #2;
        shadow_read("R9", 1'b1);
        par_kill = 1'b0;
        @(negedge clk);
        #2;
        shadow_read("R9", 1'b0);
        card_sel = 1'b1;
        @(negedge clk);
        #2;
        shadow_read("R9", 1'b0);
        card_sel = 1'b0;

        // Rotated config: block i mode = (i+1) % 4
        blk_mode_cfg = 16'b00_11_10_01_00_11_10_01;
        sweep(1'b0, 1'b0);

        blk_mode_cfg = '0;
        sweep(1'b0, 1'b1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired got=running exp=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule